// File: doc/BRIEF.md
# Contiguous Free-Entry Run Allocator

This block keeps one valid bit per entry of a table. Entries are handed out in contiguous runs. A request names a search window (a first index and an entry count) and a run length. The block scans the window from low indices to high, one candidate start index per clock cycle. It stops at the first start whose run of entries is entirely free.

On a hit it pulses `grant`, reports the start index and sets the valid bits of the whole run in the same edge. If no position fits, or the request is malformed, it pulses `fail` and leaves the table untouched. A separate release port clears the valid bits of a run given by its start and length.

Callers use it to reserve blocks of consecutive translation slots or buffer descriptors. They wait while `busy` is high and then read exactly one of `grant` or `fail`.

Top module: `run_alloc`

## Requirements
- R1: After a synchronous active-low reset, every entry is free and `busy`, `grant` and `fail` are low.
- R2: A request with a run length of zero ends with a `fail` pulse in the cycle after acceptance, without a scan and with `busy` staying low.
- R3: A request whose run length is greater than the window entry count fails in the cycle after acceptance, without a scan.
- R4: A request whose window reaches past the table end (first index plus count greater than the table size) fails in the cycle after acceptance, without a scan.
- R5: A successful request grants the lowest start index in the window at which all run-length entries are free.
- R6: Only start indices from the first index up to first + count − length are tried, so a granted run lies entirely inside the window. A run that ends exactly at the window edge is allowed.
- R7: After a grant, all entries from the start through start + length − 1 are valid and are not handed out again until released.
- R8: A request that finds no fitting position fails and changes no valid bit.
- R9: A release clears the valid bits of the entries from its start through start + length − 1. Positions beyond the table end are dropped and do not wrap to index 0.
- R10: One candidate is examined per cycle. `busy` is high while scanning. A request that tries k candidates ends with its `grant` or `fail` pulse exactly k cycles after acceptance. `grant` and `fail` are one-cycle pulses and never occur together.
- R11: A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Allocation request, accepted when `busy` is low |
| req_first | input | IDXW | First index of the search window |
| req_count | input | CNTW | Number of entries in the window |
| req_len | input | CNTW | Length of the run wanted |
| rel_valid | input | 1 | Release strobe |
| rel_start | input | IDXW | First entry of the run to free |
| rel_len | input | CNTW | Length of the run to free |
| busy | output | 1 | Scan in progress |
| grant | output | 1 | One-cycle pulse: run found and reserved |
| fail | output | 1 | One-cycle pulse: request refused or no fit |
| grant_start | output | IDXW | Start index of the last granted run |

## Verification
Some properties are checked by assertions on every cycle. `grant` and `fail` are exclusive and never coincide with `busy`. A granted run is fully valid and lies inside the table. A failed search without a release leaves the valid vector unchanged.

Other properties are only visible in the bench scenarios. These are first-fit selection, the exact number of scan cycles and the treatment of the window edges. They also include release truncation at the table end and requests ignored while busy. The bench checks these against a reference model across fragmented table patterns.

// File: rtl/run_alloc_pkg.sv
`timescale 1ns/1ps
// Shared types for the run allocator.
package run_alloc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;
endpackage

// File: rtl/run_mask.sv
`timescale 1ns/1ps
// run_mask: decodes (start, len) into a one-hot-range mask over NUM_ENTRIES.
// Assumes len may push the end beyond the table; such positions are dropped.
module run_mask #(
    parameter int NUM_ENTRIES = 64,
    parameter int IDXW        = 6,
    parameter int CNTW        = 7
) (
    input  logic [IDXW-1:0]        start,
    input  logic [CNTW-1:0]        len,
    output logic [NUM_ENTRIES-1:0] mask
);
    localparam int EW = (IDXW > CNTW ? IDXW : CNTW) + 1;

    logic [EW-1:0] start_w;
    logic [EW-1:0] end_w;

    // Exclusive end of the run in widened arithmetic.
    always_comb begin
        start_w = EW'(start);
        end_w   = EW'(start) + EW'(len);
    end

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_bit
        localparam logic [EW-1:0] IV = EW'(i);
        assign mask[i] = (IV >= start_w) && (IV < end_w);
    end
endmodule

// File: rtl/valid_table.sv
`timescale 1ns/1ps
// valid_table: one valid bit per entry; range clear and range set per edge.
// Assumes set wins over clear when both touch the same entry.
module valid_table #(
    parameter int NUM_ENTRIES = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_en,
    input  logic [NUM_ENTRIES-1:0] set_mask,
    input  logic                   clr_en,
    input  logic [NUM_ENTRIES-1:0] clr_mask,
    output logic [NUM_ENTRIES-1:0] valid
);
    // Update the bit vector: clear first, then set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
        end else begin
            valid <= (valid & ~(clr_en ? clr_mask : '0)) | (set_en ? set_mask : '0);
        end
    end
endmodule

// File: rtl/scan_ctrl.sv
`timescale 1ns/1ps
// scan_ctrl: accepts a request, screens malformed ones, then steps one
// candidate per cycle until a free run is reported or the window is used up.
// Assumes cand_blocked is combinational on cand/len_q in the same cycle.
module scan_ctrl
    import run_alloc_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int IDXW        = 6,
    parameter int CNTW        = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [IDXW-1:0] req_first,
    input  logic [CNTW-1:0] req_count,
    input  logic [CNTW-1:0] req_len,
    input  logic            cand_blocked,
    output logic            busy,
    output logic            grant,
    output logic            fail,
    output logic            take_run,
    output logic [IDXW-1:0] cand,
    output logic [CNTW-1:0] len_q,
    output logic [IDXW-1:0] grant_start
);
    localparam int EW = (IDXW > CNTW ? IDXW : CNTW) + 1;

    scan_state_e     state;
    logic [IDXW-1:0] last;
    logic [EW-1:0]   win_end;
    logic            bad_req;
    logic [EW-1:0]   last_w;

    // Screen the incoming request and find its last candidate start.
    always_comb begin
        win_end = EW'(req_first) + EW'(req_count);
        bad_req = (req_len == '0) || (req_len > req_count) ||
                  (win_end > EW'(NUM_ENTRIES));
        last_w  = win_end - EW'(req_len);
    end

    assign busy     = (state == ST_SCAN);
    assign take_run = (state == ST_SCAN) && !cand_blocked;

    // Request acceptance, candidate stepping and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cand        <= '0;
            last        <= '0;
            len_q       <= '0;
            grant       <= 1'b0;
            fail        <= 1'b0;
            grant_start <= '0;
        end else begin
            grant <= 1'b0;
            fail  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (bad_req) begin
                            fail <= 1'b1;
                        end else begin
                            state <= ST_SCAN;
                            cand  <= req_first;
                            last  <= IDXW'(last_w);
                            len_q <= req_len;
                        end
                    end
                end
                ST_SCAN: begin
                    if (!cand_blocked) begin
                        grant       <= 1'b1;
                        grant_start <= cand;
                        state       <= ST_IDLE;
                    end else if (cand == last) begin
                        fail  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        cand <= cand + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, fail}));

    // R10
    result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || fail) |-> !busy);

    // R6
    grant_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (EW'(grant_start) + EW'(len_q) <= EW'(NUM_ENTRIES)));
endmodule

// File: rtl/run_alloc.sv
`timescale 1ns/1ps
// run_alloc: first-fit allocator of contiguous free entries in a window of
// a valid-bit table, with a release port that frees a run.
// Assumes callers wait for busy low; release may arrive at any cycle.
module run_alloc #(
    parameter int NUM_ENTRIES = 64,
    parameter int IDXW        = $clog2(NUM_ENTRIES),
    parameter int CNTW        = $clog2(NUM_ENTRIES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [IDXW-1:0] req_first,
    input  logic [CNTW-1:0] req_count,
    input  logic [CNTW-1:0] req_len,
    input  logic            rel_valid,
    input  logic [IDXW-1:0] rel_start,
    input  logic [CNTW-1:0] rel_len,
    output logic            busy,
    output logic            grant,
    output logic            fail,
    output logic [IDXW-1:0] grant_start
);
    logic [NUM_ENTRIES-1:0] valid;
    logic [NUM_ENTRIES-1:0] cand_mask;
    logic [NUM_ENTRIES-1:0] rel_mask;
    logic [IDXW-1:0]        cand;
    logic [CNTW-1:0]        len_q;
    logic                   take_run;
    logic                   cand_blocked;

    run_mask #(.NUM_ENTRIES(NUM_ENTRIES), .IDXW(IDXW), .CNTW(CNTW)) u_cand_mask (
        .start(cand), .len(len_q), .mask(cand_mask));

    run_mask #(.NUM_ENTRIES(NUM_ENTRIES), .IDXW(IDXW), .CNTW(CNTW)) u_rel_mask (
        .start(rel_start), .len(rel_len), .mask(rel_mask));

    // A candidate is blocked when any entry it covers is already valid.
    assign cand_blocked = |(valid & cand_mask);

    valid_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
        .clk(clk), .rst_n(rst_n),
        .set_en(take_run), .set_mask(cand_mask),
        .clr_en(rel_valid), .clr_mask(rel_mask),
        .valid(valid));

    scan_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDXW(IDXW), .CNTW(CNTW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_first(req_first),
        .req_count(req_count), .req_len(req_len),
        .cand_blocked(cand_blocked),
        .busy(busy), .grant(grant), .fail(fail), .take_run(take_run),
        .cand(cand), .len_q(len_q), .grant_start(grant_start));

    // R7
    granted_run_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ((valid & cand_mask) == cand_mask));

    // R8
    fail_keeps_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !$past(rel_valid)) |-> (valid == $past(valid)));
endmodule

// File: tb/tb_run_alloc.sv
`timescale 1ns/1ps
module tb_run_alloc;
    localparam int N    = 64;
    localparam int IDXW = 6;
    localparam int CNTW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [IDXW-1:0] req_first = '0;
    logic [CNTW-1:0] req_count = '0;
    logic [CNTW-1:0] req_len = '0;
    logic rel_valid = 1'b0;
    logic [IDXW-1:0] rel_start = '0;
    logic [CNTW-1:0] rel_len = '0;
    logic busy, grant, fail;
    logic [IDXW-1:0] grant_start;

    int n_chk = 0;
    int n_bad = 0;
    bit mdl [N];

    always #2.5 clk = ~clk;

    run_alloc #(.NUM_ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_first(req_first),
        .req_count(req_count), .req_len(req_len),
        .rel_valid(rel_valid), .rel_start(rel_start), .rel_len(rel_len),
        .busy(busy), .grant(grant), .fail(fail), .grant_start(grant_start));

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit run_free(int s, int l);
        for (int k = s; k < s + l; k++) if (mdl[k]) return 1'b0;
        return 1'b1;
    endfunction

    // Allocation request; poke=1 presents a second request while busy (R11).
    task automatic do_req(int f, int c, int l, bit poke);
        int exp_start = -1;
        int exp_c = 0;
        int n = 0;
        bit bad = (l == 0) || (l > c) || (f + c > N);
        if (!bad) begin
            for (int s = f; s <= f + c - l; s++) begin
                exp_c++;
                if (run_free(s, l)) begin exp_start = s; break; end
            end
        end
        req_first = IDXW'(f); req_count = CNTW'(c); req_len = CNTW'(l);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!(grant || fail) && n < 200) begin
            if (!busy) chk(1'b0, "R10 busy during scan", 0, 1);
            if (poke && n == 0) begin
                req_len = '0; req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (exp_start >= 0) begin
            chk(grant == 1'b1, "R5 grant", int'(grant), 1);
            chk(int'(grant_start) == exp_start, "R5 start", int'(grant_start), exp_start);
            for (int k = exp_start; k < exp_start + l; k++) mdl[k] = 1'b1;
        end else begin
            chk(fail == 1'b1, bad ? "R2/R3/R4 early fail" : "R8 no fit", int'(fail), 1);
        end
        chk(n == (bad ? 0 : exp_c), "R10 cycles", n, bad ? 0 : exp_c);
        @(negedge clk);
        chk(!grant && !fail, "R10 single pulse", int'(grant) + int'(fail), 0);
        if (poke) chk(!busy, "R11 ignored while busy", int'(busy), 0);
    endtask

    task automatic do_rel(int s, int l);
        rel_start = IDXW'(s); rel_len = CNTW'(l); rel_valid = 1'b1;
        @(negedge clk);
        rel_valid = 1'b0;
        for (int k = s; k < s + l && k < N; k++) mdl[k] = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        for (int k = 0; k < N; k++) mdl[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !grant && !fail, "R1 reset outputs", int'(busy)+int'(grant)+int'(fail), 0);
        do_req(0, 64, 64, 1'b0);          // R1 all free: full table grants at 0
        do_rel(0, 64);
        do_req(0, 8, 0, 1'b0);            // R2
        do_req(4, 3, 4, 1'b0);            // R3
        do_req(60, 8, 2, 1'b0);           // R4
        do_req(0, 64, 4, 1'b0);           // R5 -> 0
        do_req(0, 64, 4, 1'b0);           // R7 -> 4
        do_rel(0, 4);                     // R9
        do_req(0, 64, 2, 1'b0);           // R9 freed slots reused -> 0
        do_req(10, 5, 5, 1'b0);           // R6 exact window fit -> 10
        do_req(8, 4, 3, 1'b0);            // R8 no fit in window
        do_req(8, 2, 2, 1'b0);            // R8 table unchanged -> 8
        do_req(20, 30, 6, 1'b1);          // R11 poke while busy
        do_req(60, 4, 4, 1'b0);           // -> 60
        do_rel(62, 8);                    // R9 truncated at table end
        do_req(0, 2, 1, 1'b0);            // R9 no wrap: 0,1 still valid
        do_req(60, 4, 2, 1'b0);           // R9 -> 62
        do_rel(0, 64);
        for (int it = 0; it < 400; it++) begin
            if ($urandom % 10 < 6) begin
                int f = $urandom % N;
                int c = $urandom % (N + 1 - f);
                int l = 1 + $urandom % 6;
                if ($urandom % 16 == 0) c = c + 3;
                if ($urandom % 20 == 0) l = 0;
                do_req(f, c, l, ($urandom % 8) == 0);
            end else begin
                do_rel($urandom % N, 1 + $urandom % 8);
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule